// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is an SPI master driven by a simple 32-bit register bus. Software picks one of eight active-low chip selects and turns it on, sets clock polarity, clock phase, word length and bit order, and then starts a transfer by writing the word to send. Each transfer moves one 8-bit or 16-bit word in both directions at the same time. When the word is done, the received word waits in a read-only register and a completion flag goes to 1. Software polls the flag and clears it before the next word.

Receive order and transmit order are set by separate bits. The master takes each receive bit a programmable number of core cycles after the SCLK edge on which the slave's data is valid. A wider setting gives slow slaves more time to drive MISO. The SCLK half period is a fixed number of core cycles, set by a parameter.

Register byte offsets: control 0x00, configuration 0x04, transmit word 0x08, receive word 0x0C, completion flag 0x10, sample timing 0x18. Reads from any other offset return zero.

Top module: `spiw_master`

## Requirements
- R1: After reset every cs_n line is high and sclk is low. The completion flag (0x10) reads 0, configuration (0x04) reads 0, and the timing register (0x18) reads 0x40, which is a sample delay of 1.
- R2: Control bits [4:2] hold a chip-select index and bit 0 turns the selected line on. cs_n[i] is low exactly when bit 0 is 1 and the index equals i, so at most one line is ever low. One bus write changes the index and the on bit together.
- R3: While no word is in flight, sclk equals configuration bit 11 (CPOL). Every word toggles sclk exactly 2×N times: N is 16 when configuration bit 5 is 1 and 8 when it is 0.
- R4: Configuration bit 12 (CPHA) sets the clocking. With CPHA=0 both sides sample on leading edges and shift on trailing edges. With CPHA=1 they shift on leading edges and sample on trailing edges. Data moves correctly in all four CPOL/CPHA combinations.
- R5: Configuration bit 13 set to 1 sends the transmit word least-significant bit first. Set to 0, it sends bit N-1 first.
- R6: Configuration bit 14 set to 1 stores the first received bit at position 0 of the receive word. Set to 0, it stores the first received bit at position N-1.
- R7: The transmit word is taken from the low N bits of the 0x08 write. After a word completes, 0x0C holds the received word in its low N bits and zeros above them.
- R8: At the end of each word, the completion flag (0x10, bit 0) becomes 1. Writing zero to 0x10 clears it. Writing a nonzero value to 0x10 leaves it unchanged.
- R9: A write to 0x08 while a word is in flight is ignored. Register 0x08 reads back the word that started the transfer, and that word is the one sent on the wire.
- R10: Timing bits [7:6] hold a sample delay d (0 to 3). Each MISO bit is captured d core cycles after its sampling edge of sclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions assume that the parameter for the SCLK half period is at least four core cycles. This keeps every delayed MISO capture inside the half period in which it was scheduled. They also assume that software clears the completion flag before each start. The bench follows both rules. It changes configuration, timing and chip selection only while no word is in flight, clears the flag before every start, and polls the flag rather than counting cycles. The slave model in the bench changes MISO only on shift edges, so every delay setting samples a stable bit.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  localparam logic [4:0] OFS_CTRL  = 5'h00;
  localparam logic [4:0] OFS_CFG   = 5'h04;
  localparam logic [4:0] OFS_TXW   = 5'h08;
  localparam logic [4:0] OFS_RXW   = 5'h0C;
  localparam logic [4:0] OFS_DONE  = 5'h10;
  localparam logic [4:0] OFS_TIME  = 5'h18;

  localparam int MAX_BITS = 16;

  typedef struct packed {
    logic       lsb_rx;
    logic       lsb_tx;
    logic       cpha;
    logic       cpol;
    logic       wide;
  } link_cfg_t;

  // Position in the word of the j-th bit on the wire.
  function automatic logic [3:0] wire_pos(input logic [4:0] j,
                                          input logic lsb,
                                          input logic wide);
    logic [4:0] last;
    last = wide ? 5'd15 : 5'd7;
    wire_pos = lsb ? j[3:0] : 4'(last - j);
  endfunction

  // Edge k (0 = first leading edge) is a sampling edge when its parity equals cpha.
  function automatic logic is_sample_edge(input logic [5:0] k, input logic cpha);
    is_sample_edge = (k[0] == cpha);
  endfunction

  function automatic logic [5:0] last_edge(input logic wide);
    last_edge = wide ? 6'd31 : 6'd15;
  endfunction

endpackage

// File: rtl/spiw_cs_decode.sv
module spiw_cs_decode #(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_on,
  input  logic [IDX_W-1:0]  cs_idx,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n[i] <= 1'b1;
      else        cs_n[i] <= !(cs_on && (cs_idx == IDX_W'(i)));
    end
  end

endmodule

// File: rtl/spiw_engine.sv
module spiw_engine
  import spiw_pkg::*;
#(
  parameter int HALF_CYC = 4,
  localparam int TICK_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] tx_word,
  input  link_cfg_t   cfg_in,
  input  logic [1:0]  dly_in,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx_word,
  output logic        sample_evt,
  output logic        cap_evt,
  output logic [1:0]  dly_now,
  output logic        wide_now
);

  link_cfg_t          cfg_q;
  logic [1:0]         dly_q;
  logic [15:0]        tx_q;
  logic [15:0]        rx_acc;
  logic               tail;
  logic [TICK_W-1:0]  tick;
  logic [5:0]         edge_k;
  logic [4:0]         tx_idx;
  logic [4:0]         rx_idx;
  logic               sclk_q;
  logic               pend;
  logic [1:0]         dcnt;
  logic               edge_evt;
  logic               tick_end;
  logic               shift_evt;

  assign tick_end   = (tick == TICK_W'(HALF_CYC - 1));
  assign edge_evt   = busy && !tail && tick_end;
  assign sample_evt = edge_evt && is_sample_edge(edge_k, cfg_q.cpha);
  assign shift_evt  = edge_evt && !is_sample_edge(edge_k, cfg_q.cpha)
                      && (edge_k != 6'd0) && (edge_k != last_edge(cfg_q.wide));
  assign cap_evt    = (sample_evt && (dly_q == 2'd0)) || (pend && (dcnt == 2'd1));

  assign sclk     = busy ? sclk_q : cfg_in.cpol;
  assign mosi     = busy && tx_q[wire_pos(tx_idx, cfg_q.lsb_tx, cfg_q.wide)];
  assign rx_word  = rx_acc;
  assign dly_now  = dly_q;
  assign wide_now = cfg_q.wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      tail   <= 1'b0;
      tick   <= '0;
      edge_k <= '0;
      tx_idx <= '0;
      cfg_q  <= '0;
      dly_q  <= 2'd1;
      tx_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        tail   <= 1'b0;
        tick   <= '0;
        edge_k <= '0;
        tx_idx <= '0;
        cfg_q  <= cfg_in;
        dly_q  <= dly_in;
        tx_q   <= cfg_in.wide ? tx_word : {8'h00, tx_word[7:0]};
        sclk_q <= cfg_in.cpol;
      end else if (busy) begin
        tick <= tick_end ? '0 : tick + TICK_W'(1);
        if (tail) begin
          if (tick_end) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else if (tick_end) begin
          sclk_q <= ~sclk_q;
          if (shift_evt) tx_idx <= tx_idx + 5'd1;
          if (edge_k == last_edge(cfg_q.wide)) tail <= 1'b1;
          else                                 edge_k <= edge_k + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_acc <= '0;
      rx_idx <= '0;
      pend   <= 1'b0;
      dcnt   <= '0;
    end else if (start && !busy) begin
      rx_acc <= '0;
      rx_idx <= '0;
      pend   <= 1'b0;
      dcnt   <= '0;
    end else begin
      if (sample_evt && (dly_q != 2'd0)) begin
        pend <= 1'b1;
        dcnt <= dly_q;
      end else if (pend) begin
        dcnt <= dcnt - 2'd1;
        if (dcnt == 2'd1) pend <= 1'b0;
      end
      if (cap_evt) begin
        rx_acc[wire_pos(rx_idx, cfg_q.lsb_rx, cfg_q.wide)] <= miso;
        rx_idx <= rx_idx + 5'd1;
      end
    end
  end

endmodule

// File: rtl/spiw_regs.sv
module spiw_regs
  import spiw_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [15:0]      rx_word,
  output link_cfg_t        cfg,
  output logic [1:0]       dly,
  output logic [15:0]      tx_word,
  output logic             start,
  output logic             cs_on,
  output logic [IDX_W-1:0] cs_idx,
  output logic             flag
);

  logic [15:0] rx_hold;

  assign start = bus_wr && (bus_addr == OFS_TXW) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      dly     <= 2'd1;
      tx_word <= '0;
      cs_on   <= 1'b0;
      cs_idx  <= '0;
      flag    <= 1'b0;
      rx_hold <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          OFS_CTRL: begin
            cs_on  <= bus_wdata[0];
            cs_idx <= bus_wdata[2 +: IDX_W];
          end
          OFS_CFG: begin
            cfg.wide   <= bus_wdata[5];
            cfg.cpol   <= bus_wdata[11];
            cfg.cpha   <= bus_wdata[12];
            cfg.lsb_tx <= bus_wdata[13];
            cfg.lsb_rx <= bus_wdata[14];
          end
          OFS_TIME: dly <= bus_wdata[7:6];
          OFS_TXW:  if (!busy) tx_word <= bus_wdata[15:0];
          default: ;
        endcase
      end
      if (done) begin
        flag    <= 1'b1;
        rx_hold <= rx_word;
      end else if (bus_wr && (bus_addr == OFS_DONE) && (bus_wdata == 32'd0)) begin
        flag <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[0]           = cs_on;
        bus_rdata[2 +: IDX_W]  = cs_idx;
      end
      OFS_CFG: begin
        bus_rdata[5]  = cfg.wide;
        bus_rdata[11] = cfg.cpol;
        bus_rdata[12] = cfg.cpha;
        bus_rdata[13] = cfg.lsb_tx;
        bus_rdata[14] = cfg.lsb_rx;
      end
      OFS_TXW:  bus_rdata[15:0] = tx_word;
      OFS_RXW:  bus_rdata[15:0] = rx_hold;
      OFS_DONE: bus_rdata[0]    = flag;
      OFS_TIME: bus_rdata[7:6]  = dly;
      default: ;
    endcase
  end

endmodule

// File: rtl/spiw_master.sv
module spiw_master
  import spiw_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int HALF_CYC = 4,
  localparam int IDX_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  link_cfg_t        cfg;
  logic [1:0]       dly;
  logic [15:0]      tx_word;
  logic [15:0]      rx_word;
  logic             start;
  logic             eng_busy;
  logic             eng_done;
  logic             cs_on;
  logic [IDX_W-1:0] cs_idx;
  logic             flag;
  logic             sample_evt;
  logic             cap_evt;
  logic [1:0]       dly_now;
  logic             wide_now;

  spiw_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(eng_busy), .done(eng_done), .rx_word(rx_word),
    .cfg(cfg), .dly(dly), .tx_word(tx_word), .start(start),
    .cs_on(cs_on), .cs_idx(cs_idx), .flag(flag)
  );

  spiw_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tx_word(bus_wdata[15:0]), .cfg_in(cfg), .dly_in(dly), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx_word(rx_word),
    .sample_evt(sample_evt), .cap_evt(cap_evt), .dly_now(dly_now), .wide_now(wide_now)
  );

  spiw_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .cs_on(cs_on), .cs_idx(cs_idx), .cs_n(cs_n)
  );

endmodule

// File: rtl/spiw_checks.sv
module spiw_checks #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              cs_on,
  input logic              sclk,
  input logic              busy,
  input logic              start,
  input logic              done,
  input logic              flag,
  input logic              bus_wr,
  input logic [4:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [15:0]       tx_word,
  input logic              sample_evt,
  input logic              cap_evt,
  input logic [1:0]        dly_now,
  input logic              wide_now
);

  logic       sclk_d;
  logic [5:0] tog_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      tog_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (start)              tog_cnt <= '0;
      else if (sclk != sclk_d) tog_cnt <= tog_cnt + 6'd1;
    end
  end

  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_cs_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |=> (&cs_n));

  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy == 1'b0) |-> (tog_cnt == (wide_now ? 6'd32 : 6'd16)));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_wr && bus_addr == 5'h10 && bus_wdata == 32'd0)) |=> flag);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == 5'h08) |=> $stable(tx_word));

  p_cap_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && dly_now == 2'd0) |-> cap_evt);

  p_cap_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && dly_now == 2'd1) |=> cap_evt);

  p_cap_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && dly_now == 2'd2) |=> !cap_evt);

endmodule

bind spiw_master spiw_checks #(.NUM_CS(NUM_CS)) u_checks (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_on(cs_on), .sclk(sclk),
  .busy(eng_busy), .start(start), .done(eng_done), .flag(flag),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_word(tx_word),
  .sample_evt(sample_evt), .cap_evt(cap_evt), .dly_now(dly_now), .wide_now(wide_now)
);

// File: tb/test_spiw_master.sv
module test_spiw_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic        miso_r = 1'b0;
  logic [7:0]  cs_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  spiw_master i_spiw_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso_r), .cs_n(cs_n)
  );

  // slave model
  logic        s_cpha = 1'b0;
  int          s_n = 8;
  int          s_edges = 0;
  int          s_sidx = 0;
  int          s_midx = 0;
  logic [15:0] s_seq = '0;
  logic [15:0] s_cap = '0;

  always @(sclk) begin
    if (cs_n != 8'hFF && rst_n) begin
      if ((s_edges % 2) == int'(s_cpha)) begin
        if (s_sidx < s_n) begin
          s_cap[s_sidx] = mosi;
          s_sidx++;
        end
      end else if (!s_cpha) begin
        if (s_midx < s_n - 1) begin
          s_midx++;
          miso_r = s_seq[s_midx];
        end
      end else begin
        if (s_midx < s_n) begin
          miso_r = s_seq[s_midx];
          s_midx++;
        end
      end
      s_edges++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_flag(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 400 && !ok; i++) begin
      rd(5'h10, v);
      if (v[0]) ok = 1'b1;
    end
  endtask

  function automatic logic [15:0] wire_seq(input logic [15:0] w, input int n, input bit lsb);
    logic [15:0] r = '0;
    for (int j = 0; j < n; j++) r[j] = lsb ? w[j] : w[n-1-j];
    return r;
  endfunction

  task automatic run_word(input bit cpol, input bit cpha, input bit wide,
                          input bit txl, input bit rxl, input logic [1:0] d,
                          input logic [15:0] tx, input logic [15:0] seq,
                          input logic [2:0] idx);
    int n = wide ? 16 : 8;
    logic [31:0] v;
    logic [15:0] exp_rx = '0;
    logic [15:0] txm = wide ? tx : {8'h00, tx[7:0]};
    bit ok;
    wr(5'h04, (32'(cpol) << 11) | (32'(cpha) << 12) | (32'(wide) << 5)
              | (32'(txl) << 13) | (32'(rxl) << 14));
    wr(5'h18, 32'(d) << 6);
    @(negedge clk);
    check("R3 idle sclk", 32'(sclk), 32'(cpol));
    s_cpha = cpha; s_n = n; s_edges = 0; s_sidx = 0; s_midx = 0;
    s_seq = seq; s_cap = '0;
    miso_r = cpha ? 1'b0 : seq[0];
    wr(5'h00, {27'd0, idx, 2'b01});
    wr(5'h10, 32'd0);
    wr(5'h08, {16'hBEEF, tx});
    wait_flag(ok);
    check("R8 flag set", 32'(ok), 32'd1);
    for (int j = 0; j < n; j++) exp_rx[rxl ? j : n-1-j] = seq[j];
    rd(5'h0C, v);
    check("R4 R6 R7 rx word", v, {16'd0, exp_rx});
    check("R5 wire order", {16'd0, s_cap}, {16'd0, wire_seq(txm, n, txl)});
    check("R3 edge count", 32'(s_edges), 32'(2*n));
    wr(5'h00, 32'd0);
  endtask

  initial begin
    #4000000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", {24'd0, cs_n}, 32'h0000_00FF);
    check("R1 sclk", 32'(sclk), 32'd0);
    rd(5'h10, v); check("R1 flag", v, 32'd0);
    rd(5'h04, v); check("R1 cfg", v, 32'd0);
    rd(5'h18, v); check("R1 timing", v, 32'h40);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 chip select sweep
    for (int i = 0; i < 8; i++) begin
      for (int on = 0; on < 2; on++) begin
        wr(5'h00, (32'(i) << 2) | 32'(on));
        @(negedge clk);
        check("R2 cs decode", {24'd0, cs_n},
              on ? {24'd0, ~(8'd1 << i)} : 32'h0000_00FF);
      end
    end
    wr(5'h00, 32'h1);
    wr(5'h00, (32'd6 << 2) | 32'd1);
    @(negedge clk);
    check("R2 index change", {24'd0, cs_n}, 32'h0000_00BF);
    wr(5'h00, 32'd0);

    // default delay word, then full sweep
    run_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 16'h00A5, 16'h0036, 3'd0);
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int o = 0; o < 4; o++)
          for (int d = 0; d < 4; d++)
            run_word(m[1], m[0], w[0], o[0], o[1], 2'(d),
                     16'(16'h1357 * (m + 1) + 16'h2B1 * (o + 3) + 16'h45 * d + w),
                     16'(16'h9E37 ^ (16'h0F31 * (m * 8 + o * 2 + d + 1))),
                     3'(m + o));

    // R8 clear semantics
    wr(5'h10, 32'h5);
    rd(5'h10, v); check("R8 nonzero write keeps flag", v, 32'd1);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 zero write clears", v, 32'd0);

    // R9 write while busy ignored
    wr(5'h04, 32'd0);
    wr(5'h18, 32'h40);
    s_cpha = 1'b0; s_n = 8; s_edges = 0; s_sidx = 0; s_midx = 0;
    s_seq = 16'h00C3; s_cap = '0; miso_r = 1'b1;
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h0000_00A5);
    repeat (10) @(negedge clk);
    wr(5'h08, 32'h0000_003C);
    wait_flag(ok);
    check("R9 flag", 32'(ok), 32'd1);
    rd(5'h08, v); check("R9 txw readback", v, 32'h0000_00A5);
    check("R9 wire kept", {16'd0, s_cap}, {16'd0, wire_seq(16'h00A5, 8, 1'b0)});
    rd(5'h0C, v); check("R7 R10 rx default", v, 32'h0000_00C3);
    wr(5'h00, 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule